// File: doc/BRIEF.md
# Sticky-Owner Coherence Directory for One Memory Block

This controller keeps the coherence record for a single memory block that up to four processors share. It serves read-shared (GETS), read-exclusive (GETX) and writeback (PUTX) requests. When a transaction still uses the block, the controller keeps conflict detection working after the owner has evicted it. A transactional writeback leaves the block in a sticky-modified state that still names the evicting processor. Later requests go on being forwarded to that processor. Its responder side either refuses them with a NACK or lets them through with a CLEAN. Stale sticky records are never scrubbed. The next request resolves them.

Each processor has a responder slice. The slice holds that processor's single overflow bit and a flag that records whether it is holding back an older transaction. It also holds the timestamp of that processor's latest request. The read/write tracking bits for this block come in on plain pins, one pair per processor. Requests enter on a valid/ready channel and replies leave on another. Only one request is in service at a time. `req_ready` is low from the cycle after an acceptance until the reply has been taken. The reply register holds its contents for as long as `resp_ready` is low. Every decision is based on the state that was held before the clock edge that accepts the request.

Top module: `stkdir_ctrl`

## Requirements
- R1: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. Its reply appears one cycle later with `resp_dst` equal to the requester. While the reply waits, `req_ready` is low and `resp_kind`/`resp_dst` stay stable until a rising edge at which `resp_ready` is high.
- R2: Request codes are 0 GETS, 1 GETX, 2 PUTX and 3 reserved. Reply codes are 0 ACK, 1 DATA, 2 NACK-retry and 3 NACK-abort. State codes are 0 invalid, 1 shared, 2 modified and 3 sticky-modified. A GETS to an invalid or shared block replies DATA and moves the block to shared with the requester added to the sharer mask. A GETX that nobody refuses replies DATA, makes the requester the owner in modified, and clears the sharer mask.
- R3: In modified state, a GETS from another processor is refused when the owner's write bit is set. Otherwise it replies DATA and the block becomes shared by the owner and the requester. A GETX from another processor is refused when the owner's read or write bit is set. A GETS or GETX from the owner itself replies DATA and changes nothing.
- R4: In shared state, a GETX is refused when any sharer other than the requester has its read or write bit set.
- R5: A PUTX from the owner of a modified block replies ACK. If the owner's write bit is set, the block goes to sticky-modified with the same owner and the owner's overflow bit is set. Otherwise the block goes to invalid. Any other PUTX, and any reserved code, replies ACK and changes nothing.
- R6: In sticky-modified state, a GETS or GETX from another processor goes to the recorded owner. That owner refuses when its overflow bit is set and its tracking shows a conflict, which for GETS is the write bit and for GETX is the read or write bit. Otherwise it answers CLEAN, the requester gets DATA, and the block becomes shared with the requester alone (GETS) or modified and owned by the requester (GETX). A request from the recorded owner itself counts as CLEAN.
- R7: A refused request leaves the state, the owner and the sharer mask unchanged.
- R8: A `tx_end` pulse for a processor clears its overflow bit and its stall flag, and leaves the sticky record untouched. When a `tx_end` pulse and a setting event for the same processor fall in the same cycle, the clear wins.
- R9: A refusal replies code 3 when the requester's stall flag is set, and code 2 otherwise. A processor's stall flag is set when it refuses a request whose timestamp is strictly smaller than the timestamp of its own latest accepted request. After reset that stored timestamp is 0.
- R10: After reset the block is invalid with an empty sharer mask. All overflow bits are clear, no reply is pending, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_kind | input | 2 | Request code |
| req_src | input | PW | Requesting processor |
| req_ts | input | TS_W | Transaction timestamp of the request |
| trk_rd | input | NPROC | Per-processor transactional read bit for this block |
| trk_wr | input | NPROC | Per-processor transactional write bit for this block |
| tx_end | input | NPROC | Per-processor commit/abort pulse |
| resp_valid | output | 1 | Reply present |
| resp_ready | input | 1 | Receiver takes the reply |
| resp_kind | output | 2 | Reply code |
| resp_dst | output | PW | Processor the reply is for |
| dir_state | output | 2 | Directory state code |
| dir_owner | output | PW | Recorded owner (meaningful in states 2 and 3) |
| dir_sharers | output | NPROC | Sharer mask |
| ovf_bits | output | NPROC | Per-processor overflow bits |

## Verification
The bench builds the controller with its default values: four processors and 8-bit timestamps. With only four sources, random traffic keeps hitting the block's current owner. This makes writebacks that land in sticky-modified frequent, and later requests then meet both a set and a cleared overflow bit. Timestamps are drawn from a small range, so both older and newer orderings occur and the retry and abort replies both appear. Directed sequences add the cases random traffic rarely builds: the same-cycle clear of an overflow bit, and a processor that is stalling an older transaction and is then refused itself.

// File: rtl/stkdir_pkg.sv
package stkdir_pkg;
  typedef enum logic [1:0] {
    DS_I  = 2'd0,
    DS_S  = 2'd1,
    DS_M  = 2'd2,
    DS_SM = 2'd3
  } dstate_e;

  localparam logic [1:0] RQ_GETS = 2'd0;
  localparam logic [1:0] RQ_GETX = 2'd1;
  localparam logic [1:0] RQ_PUTX = 2'd2;

  localparam logic [1:0] RS_ACK   = 2'd0;
  localparam logic [1:0] RS_DATA  = 2'd1;
  localparam logic [1:0] RS_RETRY = 2'd2;
  localparam logic [1:0] RS_ABORT = 2'd3;
endpackage

// File: rtl/stkdir_responder.sv
module stkdir_responder #(
  parameter int TS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  logic            acc_me,
  input  logic            fwd_hit,
  input  logic            fwd_excl,
  input  logic            fwd_sticky,
  input  logic [TS_W-1:0] req_ts,
  input  logic            trk_rd,
  input  logic            trk_wr,
  input  logic            tx_end,
  input  logic            set_ovf,
  output logic            nack,
  output logic            ovf,
  output logic            stall_older
);
  logic            ovf_q, stall_q;
  logic [TS_W-1:0] own_ts_q;
  logic            conflict;

  assign conflict = fwd_excl ? (trk_rd | trk_wr) : trk_wr;
  // in-cache refusals need only tracking; sticky ones also need the overflow bit
  assign nack = acc & fwd_hit & conflict & (~fwd_sticky | ovf_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q    <= 1'b0;
      stall_q  <= 1'b0;
      own_ts_q <= '0;
    end else begin
      if (tx_end) begin
        ovf_q   <= 1'b0;
        stall_q <= 1'b0;
      end else begin
        if (set_ovf) ovf_q <= 1'b1;
        if (nack && (req_ts < own_ts_q)) stall_q <= 1'b1;
      end
      if (acc_me) own_ts_q <= req_ts;
    end
  end

  assign ovf         = ovf_q;
  assign stall_older = stall_q;

  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_end) |-> (!ovf_q && !stall_q)); // R8
endmodule

// File: rtl/stkdir_fsm.sv
module stkdir_fsm import stkdir_pkg::*; #(
  parameter int NPROC = 4,
  parameter int PW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [1:0]       req_kind,
  input  logic [PW-1:0]    req_src,
  input  logic [NPROC-1:0] trk_wr,
  input  logic             nack_any,
  input  logic             stall_src,
  input  logic             resp_ready,
  output logic [NPROC-1:0] fwd_mask,
  output logic             fwd_sticky,
  output logic [NPROC-1:0] set_ovf,
  output logic             resp_valid,
  output logic [1:0]       resp_kind,
  output logic [PW-1:0]    resp_dst,
  output dstate_e          state,
  output logic [PW-1:0]    owner,
  output logic [NPROC-1:0] sharers
);
  localparam logic [NPROC-1:0] ONE = NPROC'(1);

  dstate_e          state_q, st_d;
  logic [PW-1:0]    owner_q, own_d, rdst_q, rdst_d;
  logic [NPROC-1:0] sharers_q, sh_d, src_oh, own_oh;
  logic             rv_q, rv_d;
  logic [1:0]       rk_q, rk_d;
  logic             is_get, from_owner;

  assign src_oh     = ONE << req_src;
  assign own_oh     = ONE << owner_q;
  assign is_get     = (req_kind == RQ_GETS) || (req_kind == RQ_GETX);
  assign from_owner = (req_src == owner_q);

  always_comb begin
    fwd_mask   = '0;
    fwd_sticky = 1'b0;
    if (is_get && !from_owner && (state_q == DS_M || state_q == DS_SM)) begin
      fwd_mask   = own_oh;
      fwd_sticky = (state_q == DS_SM);
    end else if (req_kind == RQ_GETX && state_q == DS_S) begin
      fwd_mask = sharers_q & ~src_oh;
    end
  end

  assign set_ovf = (acc && state_q == DS_M && req_kind == RQ_PUTX && from_owner &&
                    trk_wr[req_src]) ? src_oh : '0;

  always_comb begin
    st_d   = state_q;
    own_d  = owner_q;
    sh_d   = sharers_q;
    rv_d   = rv_q & ~resp_ready;
    rk_d   = rk_q;
    rdst_d = rdst_q;
    if (acc) begin
      rv_d   = 1'b1;
      rdst_d = req_src;
      rk_d   = RS_ACK;
      if (is_get) begin
        if (nack_any) begin
          rk_d = stall_src ? RS_ABORT : RS_RETRY;
        end else begin
          rk_d = RS_DATA;
          if (req_kind == RQ_GETX) begin
            if (!(state_q == DS_M && from_owner)) begin
              st_d  = DS_M;
              own_d = req_src;
              sh_d  = '0;
            end
          end else begin
            unique case (state_q)
              DS_I, DS_SM: begin st_d = DS_S; sh_d = src_oh; end
              DS_S:        sh_d = sharers_q | src_oh;
              DS_M: if (!from_owner) begin st_d = DS_S; sh_d = own_oh | src_oh; end
            endcase
          end
        end
      end else if (req_kind == RQ_PUTX && state_q == DS_M && from_owner) begin
        st_d = trk_wr[req_src] ? DS_SM : DS_I;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= DS_I;
      owner_q   <= '0;
      sharers_q <= '0;
      rv_q      <= 1'b0;
      rk_q      <= RS_ACK;
      rdst_q    <= '0;
    end else begin
      state_q   <= st_d;
      owner_q   <= own_d;
      sharers_q <= sh_d;
      rv_q      <= rv_d;
      rk_q      <= rk_d;
      rdst_q    <= rdst_d;
    end
  end

  assign resp_valid = rv_q;
  assign resp_kind  = rk_q;
  assign resp_dst   = rdst_q;
  assign state      = state_q;
  assign owner      = owner_q;
  assign sharers    = sharers_q;

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rv_q && !resp_ready) |=> (rv_q && $stable(rk_q) && $stable(rdst_q))); // R1
  AST_SHARERS_ONLY_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != DS_S) |-> (sharers_q == '0)); // R2
  AST_NACK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rv_q) && rk_q[1]) |->
      (state_q == $past(state_q) && owner_q == $past(owner_q) &&
       sharers_q == $past(sharers_q))); // R7
  AST_ACK_NOT_GET: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rv_q) && rk_q == RS_ACK) |->
      ($past(req_kind) != RQ_GETS && $past(req_kind) != RQ_GETX)); // R5
endmodule

// File: rtl/stkdir_ctrl.sv
module stkdir_ctrl import stkdir_pkg::*; #(
  parameter int NPROC = 4,
  parameter int TS_W  = 8,
  localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [PW-1:0]    req_src,
  input  logic [TS_W-1:0]  req_ts,
  input  logic [NPROC-1:0] trk_rd,
  input  logic [NPROC-1:0] trk_wr,
  input  logic [NPROC-1:0] tx_end,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic [1:0]       resp_kind,
  output logic [PW-1:0]    resp_dst,
  output logic [1:0]       dir_state,
  output logic [PW-1:0]    dir_owner,
  output logic [NPROC-1:0] dir_sharers,
  output logic [NPROC-1:0] ovf_bits
);
  logic             acc, fwd_sticky;
  logic [NPROC-1:0] fwd_mask, set_ovf, nack_vec, stall_vec;
  dstate_e          st;

  assign req_ready = ~resp_valid;
  assign acc       = req_valid & req_ready;
  assign dir_state = st;

  stkdir_fsm #(.NPROC(NPROC), .PW(PW)) fsm_i (
    .clk(clk), .rst_n(rst_n), .acc(acc), .req_kind(req_kind), .req_src(req_src),
    .trk_wr(trk_wr), .nack_any(|nack_vec), .stall_src(stall_vec[req_src]),
    .resp_ready(resp_ready), .fwd_mask(fwd_mask), .fwd_sticky(fwd_sticky),
    .set_ovf(set_ovf), .resp_valid(resp_valid), .resp_kind(resp_kind),
    .resp_dst(resp_dst), .state(st), .owner(dir_owner), .sharers(dir_sharers)
  );

  for (genvar p = 0; p < NPROC; p++) begin : g_proc
    stkdir_responder #(.TS_W(TS_W)) rsp_i (
      .clk(clk), .rst_n(rst_n), .acc(acc), .acc_me(acc && (req_src == PW'(p))),
      .fwd_hit(fwd_mask[p]), .fwd_excl(req_kind == RQ_GETX), .fwd_sticky(fwd_sticky),
      .req_ts(req_ts), .trk_rd(trk_rd[p]), .trk_wr(trk_wr[p]), .tx_end(tx_end[p]),
      .set_ovf(set_ovf[p]), .nack(nack_vec[p]), .ovf(ovf_bits[p]),
      .stall_older(stall_vec[p])
    );

    AST_OVF_RISE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_bits[p]) |-> (st == DS_SM && dir_owner == PW'(p))); // R5
  end
endmodule

// File: tb/stkdir_ctrl_tb_top.sv
module stkdir_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, resp_ready = 1'b0;
  logic [1:0] req_kind = '0;
  logic [1:0] req_src = '0;
  logic [7:0] req_ts = '0;
  logic [3:0] trk_rd = '0, trk_wr = '0, tx_end = '0;
  logic       req_ready, resp_valid;
  logic [1:0] resp_kind, resp_dst, dir_state, dir_owner;
  logic [3:0] dir_sharers, ovf_bits;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int       m_state, m_owner;
  bit [3:0] m_sh, m_ovf, m_stall;
  int       m_ts[4];

  always #10 clk = ~clk;

  stkdir_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_src(req_src), .req_ts(req_ts), .trk_rd(trk_rd),
    .trk_wr(trk_wr), .tx_end(tx_end), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_kind(resp_kind), .resp_dst(resp_dst), .dir_state(dir_state),
    .dir_owner(dir_owner), .dir_sharers(dir_sharers), .ovf_bits(ovf_bits)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pack();
    return {20'b0, 2'(m_state), m_sh, m_ovf, (m_state >= 2) ? 2'(m_owner) : 2'b0};
  endfunction

  function automatic logic [31:0] act_pack();
    return {20'b0, dir_state, dir_sharers, ovf_bits, (dir_state >= 2) ? dir_owner : 2'b0};
  endfunction

  // reference behaviour written from the requirements
  task automatic model_req(int kind, int src, int ts, bit [3:0] rd, bit [3:0] wr,
                           bit [3:0] tend, output int ek);
    bit [3:0] mask = '0, nk = '0, soh;
    bit sticky = 0;
    soh = 4'b1 << src;
    if (kind < 2 && m_state >= 2 && src != m_owner) begin
      mask = 4'b1 << m_owner; sticky = (m_state == 3);
    end
    if (kind == 1 && m_state == 1) mask = m_sh & ~soh;
    for (int p = 0; p < 4; p++) begin
      bit conf = (kind == 1) ? (rd[p] | wr[p]) : wr[p];
      nk[p] = mask[p] & conf & (!sticky | m_ovf[p]);
    end
    if (kind < 2) begin
      if (|nk) ek = m_stall[src] ? 3 : 2;
      else begin
        ek = 1;
        if (kind == 1) begin
          if (!(m_state == 2 && src == m_owner)) begin m_state = 2; m_owner = src; m_sh = 0; end
        end else if (m_state == 0 || m_state == 3) begin m_state = 1; m_sh = soh; end
        else if (m_state == 1) m_sh |= soh;
        else if (src != m_owner) begin m_state = 1; m_sh = soh | (4'b1 << m_owner); end
      end
    end else begin
      ek = 0;
      if (kind == 2 && m_state == 2 && src == m_owner) begin
        if (wr[src]) begin m_state = 3; m_ovf[src] = 1; end
        else m_state = 0;
      end
    end
    for (int p = 0; p < 4; p++) if (nk[p] && ts < m_ts[p]) m_stall[p] = 1;
    m_ts[src] = ts;
    m_ovf   &= ~tend;
    m_stall &= ~tend;
  endtask

  task automatic do_op(string tag, int kind, int src, int ts, bit [3:0] rd, bit [3:0] wr,
                       bit [3:0] tend, bit hold);
    int ek;
    model_req(kind, src, ts, rd, wr, tend, ek);
    @(negedge clk);
    req_valid = 1; req_kind = 2'(kind); req_src = 2'(src); req_ts = 8'(ts);
    trk_rd = rd; trk_wr = wr; tx_end = tend; resp_ready = 0;
    @(negedge clk);
    req_valid = 0; tx_end = 0;
    check({tag, " reply"}, {29'b0, resp_valid, resp_kind, resp_dst}, {29'b0, 1'b1, 2'(ek), 2'(src)});
    check({tag, " state"}, act_pack(), exp_pack());
    if (hold) begin
      @(negedge clk);
      check("R1 hold", {27'b0, req_ready, resp_valid, resp_kind, resp_dst},
            {27'b0, 1'b0, 1'b1, 2'(ek), 2'(src)});
    end
    resp_ready = 1;
    @(negedge clk);
    resp_ready = 0;
    if (resp_valid !== 1'b0 || req_ready !== 1'b1) check("R1 drain", 1, 0);
  endtask

  task automatic do_end(string tag, bit [3:0] m);
    @(negedge clk); tx_end = m;
    @(negedge clk); tx_end = 0;
    m_ovf &= ~m; m_stall &= ~m;
    check(tag, act_pack(), exp_pack());
  endtask

  initial begin
    m_state = 0; m_owner = 0; m_sh = 0; m_ovf = 0; m_stall = 0;
    for (int p = 0; p < 4; p++) m_ts[p] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 reset", {27'b0, req_ready, resp_valid, dir_state, dir_sharers == 0, ovf_bits == 0},
          {27'b0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1});
    do_op("R2 gets from I", 0, 0, 1, 0, 0, 0, 0);
    do_op("R2 gets adds sharer", 0, 1, 1, 0, 0, 0, 1);
    do_op("R4 getx refused by sharer", 1, 2, 1, 4'b0001, 0, 0, 0);
    do_op("R2 getx clean", 1, 2, 1, 0, 0, 0, 0);
    do_op("R3 gets vs owner write", 0, 3, 1, 0, 4'b0100, 0, 0);
    do_op("R3 getx vs owner read", 1, 3, 1, 4'b0100, 0, 0, 1);
    do_op("R3 owner own gets", 0, 2, 1, 0, 4'b0100, 0, 0);
    do_op("R5 transactional putx", 2, 2, 1, 0, 4'b0100, 0, 0);
    do_op("R6 sticky gets refused", 0, 0, 1, 0, 4'b0100, 0, 0);
    do_op("R6 sticky getx refused", 1, 0, 1, 4'b0100, 0, 0, 0);
    do_end("R8 end clears overflow", 4'b0100);
    do_op("R6 sticky lazy clean", 0, 0, 1, 0, 4'b0100, 0, 0);
    do_op("R5 putx non owner", 2, 3, 1, 0, 4'b1000, 0, 0);
    do_op("R5 reserved code", 3, 1, 1, 0, 0, 0, 0);
    do_op("R9 setup", 0, 1, 10, 0, 0, 0, 0);
    do_op("R9 older refused retry", 1, 2, 3, 4'b0010, 0, 0, 0);
    do_op("R9 stalled requester aborts", 1, 1, 10, 4'b0001, 0, 0, 0);
    do_end("R8 end clears stall", 4'b0010);
    do_op("R9 retry after end", 1, 1, 10, 4'b0001, 0, 0, 0);
    do_op("R2 getx take", 1, 1, 4, 0, 0, 0, 0);
    do_op("R8 same-cycle clear wins", 2, 1, 4, 0, 4'b0010, 4'b0010, 0);
    do_op("R8 sticky without overflow", 1, 3, 4, 4'b0010, 4'b0010, 0, 0);
    do_op("R5 putx to sticky", 2, 3, 4, 0, 4'b1000, 0, 0);
    do_op("R6 owner self clean", 0, 3, 4, 0, 4'b1000, 0, 0);
    void'($urandom(32'h5eed));
    for (int i = 0; i < 600; i++) begin
      int r = $urandom % 10;
      int kind = (r < 4) ? 0 : (r < 7) ? 1 : (r < 9) ? 2 : 3;
      int src = $urandom % 4;
      bit [3:0] rd = 0, wr = 0;
      if (kind == 2 && ($urandom % 10) < 7) src = m_owner;
      for (int p = 0; p < 4; p++) begin
        rd[p] = ($urandom % 10) < 3;
        wr[p] = ($urandom % 10) < 3;
      end
      do_op("R7 random", kind, src, $urandom % 64, rd, wr, 0, ($urandom % 10) < 3);
      if (($urandom % 100) < 15) do_end("R8 random end", 4'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule